// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two W-bit two's complement numbers and gives their 2W-bit signed product. It handles one multiplier bit per clock cycle. A start pulse captures the multiplicand and the multiplier. Over the next W cycles the block examines the multiplier bits from least to most significant. On each cycle it either adds the multiplicand to a running partial sum or leaves the partial sum unchanged. The partial sum is then shifted right by one place. The bit that leaves the partial sum enters the top of the multiplier register, so the low half of the product builds up in that register as the multiplier bits are used up.

The multiplier's top bit has negative weight. The block therefore subtracts the multiplicand in the final step instead of adding it. Both adder inputs are sign-extended to W+1 bits, so every partial sum stays exact. The block raises `done` for one cycle when the product is ready. It ignores a start pulse that arrives while an operation is still running.

Top module: `smul_seq`

## Requirements
- R1: When `done` is high, `product` equals the 2W-bit two's complement product of the multiplicand and multiplier that were captured at the accepted start.
- R2: If `start` is sampled high at rising edge E while the block is idle, `done` goes high just after edge E+W.
- R3: `done` stays high for exactly one cycle per accepted start.
- R4: A `start` pulse sampled while an operation is running has no effect. The running product, its `done` timing and the number of `done` pulses do not change, and operand inputs that change at that time are not captured.
- R5: A multiplier with its top bit set (negative) gives the correct signed product. This includes the most negative value times itself, which is +2^(2W-2).
- R6: A negative multiplicand gives the correct signed product because the partial sums are sign-extended. For example, -1 times -1 gives +1.
- R7: A zero operand gives a zero product. While the multiplicand is zero, the partial sum stays zero.
- R8: After reset, `done` is low and `product` is zero.
- R9: While no operation is running, `product` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| product | output | 2W | Signed product |
| done | output | 1 | One-cycle pulse when product is valid |

## Verification
Each result is due a fixed number of edges after its stimulus. The bench counts rising edges and stamps each expected product with the count at which its `done` must be high, which is the start edge plus W. The monitor samples on falling edges. It flags a `done` that comes before or after its stamped count, and it flags any `done` pulse with no expected item queued. The hold check for R9 and the stray-start check for R4 read `product` several cycles after `done`, while the block is idle.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [0:0] {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic last_step,
  output logic done
);
  import smul_pkg::*;

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  smul_state_e   state_q;
  logic [CW-1:0] step_q;
  logic          done_q;

  assign busy      = (state_q == SM_RUN);
  assign accept    = start && !busy;
  assign last_step = busy && (step_q == LAST_IDX);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SM_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        state_q <= SM_RUN;
        step_q  <= '0;
      end else if (busy) begin
        if (last_step) begin
          state_q <= SM_IDLE;
          step_q  <= '0;
        end else begin
          step_q <= step_q + ONE;
        end
      end
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> (busy && step_q == $past(step_q) + ONE));
endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] part,
  input  logic [W-1:0] mcand,
  input  logic         add_en,
  input  logic         sub,
  output logic [W:0]   sum
);
  function automatic logic [W:0] sext(input logic [W-1:0] v);
    return {v[W-1], v};
  endfunction

  function automatic logic [W:0] step_sum(input logic [W-1:0] p,
                                          input logic [W-1:0] a,
                                          input logic en,
                                          input logic neg);
    logic [W:0] opnd;
    opnd = en ? sext(a) : '0;
    return neg ? (sext(p) - opnd) : (sext(p) + opnd);
  endfunction

  assign sum = step_sum(part, mcand, add_en, sub);
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic         accept;
  logic         busy;
  logic         last_step;
  logic [W-1:0] a_q;
  logic [W-1:0] p_q;
  logic [W-1:0] x_q;
  logic [W:0]   sum;

  smul_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .busy      (busy),
    .last_step (last_step),
    .done      (done)
  );

  smul_addsub #(.W(W)) u_addsub (
    .part   (p_q),
    .mcand  (a_q),
    .add_en (x_q[0]),
    .sub    (last_step),
    .sum    (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      p_q <= '0;
      x_q <= '0;
    end else if (accept) begin
      a_q <= mcand;
      p_q <= '0;
      x_q <= mplier;
    end else if (busy) begin
      p_q <= sum[W:1];
      x_q <= {sum[0], x_q[W-1:1]};
    end
  end

  assign product = {p_q, x_q};

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(product));

  p_zero_mcand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && a_q == '0 && p_q == '0) |=> (p_q == '0));
endmodule

// File: tb/smul_seq_tb.sv
module smul_seq_tb;
  localparam int W = 8;

  typedef struct {
    logic [2*W-1:0] prod;
    int             due;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   finished = 0;
  exp_t sb[$];

  smul_seq #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier), .product(product), .done(done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb, r;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    r  = pa * pb;
    return r[2*W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    e.prod = ref_mul(a, b);
    e.due  = cyc + 1 + W;
    if (a == '0 || b == '0) e.tag = "R7";
    else if (b[W-1]) e.tag = "R5";
    else if (a[W-1]) e.tag = "R6";
    else e.tag = "R1";
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    repeat (W) @(negedge clk);
  endtask

  // monitor: compares products and done timing against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R3", "done without accepted start", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(product == e.prod, e.tag, "product", product, e.prod);
          check(cyc == e.due, "R2", "done cycle", cyc, e.due);
        end
      end else if (sb.size() > 0 && cyc >= sb[0].due) begin
        exp_t e;
        e = sb.pop_front();
        check(0, "R2", "done missing", cyc, e.due);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8", "done after reset", done, 0);
    check(product == '0, "R8", "product after reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);

    op(8'h80, 8'h80);          // R5 most negative squared
    op(8'h00, 8'h5a);          // R7
    op(8'h6b, 8'h00);          // R7
    op(8'hff, 8'hff);          // R6 -1 * -1
    op(8'hff, 8'h80);          // R5
    op(8'h7f, 8'h80);          // R5
    op(8'h80, 8'h7f);          // R6
    op(8'h7f, 8'h7f);          // R1
    op(8'h03, 8'h05);          // R1

    // R4: stray starts with different operands while running
    @(negedge clk);
    start = 1'b1; mcand = 8'h9c; mplier = 8'hd3;
    begin
      exp_t e;
      e.prod = ref_mul(8'h9c, 8'hd3);
      e.due  = cyc + 1 + W;
      e.tag  = "R4";
      sb.push_back(e);
    end
    @(negedge clk);
    for (int i = 0; i < W - 1; i++) begin
      start = 1'b1; mcand = 8'h11 + 8'(i); mplier = 8'h22;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);           // done observed here by the monitor
    held = product;
    repeat (5) @(negedge clk);
    check(product == ref_mul(8'h9c, 8'hd3), "R4", "product after stray starts",
          product, ref_mul(8'h9c, 8'hd3));
    check(product == held, "R9", "product held while idle", product, held);
    check(done == 1'b0, "R3", "done low while idle", done, 0);

    for (int i = 0; i < 40; i++) begin
      op(8'($urandom), 8'($urandom));
    end

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "queue drained", sb.size(), 0);
    finish_run();
  end
endmodule